// File: doc/BRIEF.md
# Line-Interface Power Mode Controller

This block keeps track of the power state of a line-side interface. Software controls it with two register bits: a core power-down bit and a link power-down bit, written together through a simple write port. From the current state and the order in which the bits arrive, the block settles on one of four modes: normal, reset, sleep or deep power-down. It then drives the enables for the link, the ring-detect function and the core logic.

A sleep entry takes two writes. The first write sets both bits, which opens an arming window of `ARM_CYCLES` cycles. During that window the block shows deep power-down. If a write that clears only the link bit lands inside the window, the block enters sleep. If the window closes without such a write, deep power-down becomes final. Once the block is in sleep or final deep power-down, it leaves only through a host-side reset request. That request takes effect only while the synchronized clock-present indication is high. A request made while the clock is absent is held pending until the clock returns.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode` is 2'b01 (reset mode). The mode code is {core power-down bit, link power-down bit}, so that state is core bit clear and link bit set.
- R2: In reset mode (01), `link_en`, `ring_det_en`, `link_ready` and `far_regs_valid` are low and `core_en` is high.
- R3: In reset mode, a write of 2'b00 moves the block to normal mode (00). In normal mode, all five outputs `link_en`, `core_en`, `ring_det_en`, `link_ready` and `far_regs_valid` are high.
- R4: In normal mode, a write of 2'b01 returns the block to reset mode (01).
- R5: From reset or normal mode, a write of 2'b11 opens the arming window, and `mode` reads 11. A write of 2'b10 on any of the `ARM_CYCLES` edges after that write enters sleep (10). In sleep, `link_en`, `ring_det_en` and `far_regs_valid` are high, and `core_en` and `link_ready` are low.
- R6: If no 2'b10 write arrives within the window, deep power-down (11) becomes final. A 2'b10 write after the window has no effect. In deep power-down, all five enables and flags are low.
- R7: A write of 2'b10 in reset or normal mode clears the link bit before the core bit has been set. The block ignores it, and `mode` is unchanged.
- R8: In sleep and in final deep power-down, every write is ignored.
- R9: A `host_rst_req` seen while the synchronized clock-present is high returns the block to reset mode (01) on that edge, from any mode. It takes priority over a write on the same edge.
- R10: A `host_rst_req` made while `clk_present` is low is held pending. Once `clk_present` rises, it takes effect on the edge that follows `SYNC_STAGES` edges of synchronization.
- R11: `ring_det_en` is high exactly in normal (00) and sleep (10) modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Bit 1 core power-down, bit 0 link power-down |
| host_rst_req | input | 1 | Request to reset the host-side logic |
| clk_present | input | 1 | Indication that the host clock runs, asynchronous |
| mode | output | 2 | 00 normal, 01 reset, 10 sleep, 11 deep power-down |
| link_en | output | 1 | Link enable |
| core_en | output | 1 | Host-side core enable |
| ring_det_en | output | 1 | Ring-detect (wake) enable |
| link_ready | output | 1 | Link is carrying data in both directions |
| far_regs_valid | output | 1 | Far-side register contents may be trusted |

## Verification
The bench builds the block with `ARM_CYCLES` set to 4 and `SYNC_STAGES` left at 2. With the short window, the two boundaries can be reached exactly in a few cycles: a sleep write on the last edge of the window, and one on the first edge after it closes. Two synchronizer stages make the pending-reset delay after the clock returns three edges. That is long enough to check both the cycle before acceptance and the cycle of acceptance.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RESET  = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_DEEP   = 2'b11
  } pmc_mode_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_NORMAL,
    ST_ARMED,
    ST_SLEEP,
    ST_DEEP
  } pmc_state_e;

  typedef struct packed {
    logic link_en;
    logic core_en;
    logic ring_en;
    logic link_ready;
    logic far_valid;
  } pmc_gate_t;

  // Reported code equals {core power-down bit, link power-down bit}
  function automatic pmc_mode_e state_to_mode(pmc_state_e s);
    case (s)
      ST_NORMAL: return MODE_NORMAL;
      ST_RESET:  return MODE_RESET;
      ST_SLEEP:  return MODE_SLEEP;
      default:   return MODE_DEEP;
    endcase
  endfunction

  function automatic pmc_gate_t mode_gates(pmc_mode_e m);
    pmc_gate_t g;
    case (m)
      MODE_NORMAL: g = '{link_en: 1'b1, core_en: 1'b1, ring_en: 1'b1, link_ready: 1'b1, far_valid: 1'b1};
      MODE_RESET:  g = '{link_en: 1'b0, core_en: 1'b1, ring_en: 1'b0, link_ready: 1'b0, far_valid: 1'b0};
      MODE_SLEEP:  g = '{link_en: 1'b1, core_en: 1'b0, ring_en: 1'b1, link_ready: 1'b0, far_valid: 1'b1};
      default:     g = '{link_en: 1'b0, core_en: 1'b0, ring_en: 1'b0, link_ready: 1'b0, far_valid: 1'b0};
    endcase
    return g;
  endfunction

  // Legal-order decode of a two-bit write; illegal writes keep the state
  function automatic pmc_state_e next_on_write(pmc_state_e s, logic [1:0] w);
    pmc_state_e n;
    n = s;
    case (s)
      ST_RESET: begin
        if (w == 2'b00)      n = ST_NORMAL;
        else if (w == 2'b11) n = ST_ARMED;
      end
      ST_NORMAL: begin
        if (w == 2'b01)      n = ST_RESET;
        else if (w == 2'b11) n = ST_ARMED;
      end
      ST_ARMED: begin
        if (w == 2'b10)      n = ST_SLEEP;
      end
      default: n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pmc_clk_sync.sv
module pmc_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= async_in;
      end
      assign sync_out = q;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
      assign sync_out = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pmc_wake_ctrl.sv
module pmc_wake_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clk_ok,
  output logic accept,
  output logic pending
);

  assign accept = (req | pending) & clk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (accept) pending <= 1'b0;
    else if (req)    pending <= 1'b1;
  end

endmodule

// File: rtl/pmc_arm_timer.sv
module pmc_arm_timer #(
  parameter int ARM_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  output logic expire
);

  localparam int CNT_W = (ARM_CYCLES > 1) ? $clog2(ARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ARM_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = armed && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!armed) cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_bits,
  input  logic       accept,
  input  logic       expire,
  output pmc_state_e state_q
);

  pmc_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = ST_RESET;
    end else begin
      if (wr_en) state_d = next_on_write(state_q, wr_bits);
      if (state_d == ST_ARMED && expire) state_d = ST_DEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int ARM_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_wdata,
  input  logic       host_rst_req,
  input  logic       clk_present,
  output logic [1:0] mode,
  output logic       link_en,
  output logic       core_en,
  output logic       ring_det_en,
  output logic       link_ready,
  output logic       far_regs_valid
);

  // Named internal events, also observed by the bound checker
  logic       clk_ok;
  logic       host_accept;
  logic       rst_pending;
  logic       arm_open;
  logic       arm_expire;
  pmc_state_e state;
  pmc_mode_e  mode_code;
  pmc_gate_t  gates;

  pmc_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (clk_present),
    .sync_out (clk_ok)
  );

  pmc_wake_ctrl u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (host_rst_req),
    .clk_ok  (clk_ok),
    .accept  (host_accept),
    .pending (rst_pending)
  );

  assign arm_open = (state == ST_ARMED);

  pmc_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (arm_open),
    .expire (arm_expire)
  );

  pmc_mode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we),
    .wr_bits (reg_wdata),
    .accept  (host_accept),
    .expire  (arm_expire),
    .state_q (state)
  );

  assign mode_code      = state_to_mode(state);
  assign gates          = mode_gates(mode_code);
  assign mode           = mode_code;
  assign link_en        = gates.link_en;
  assign core_en        = gates.core_en;
  assign ring_det_en    = gates.ring_en;
  assign link_ready     = gates.link_ready;
  assign far_regs_valid = gates.far_valid;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_wdata,
  input logic       host_rst_req,
  input logic       clk_ok,
  input logic       host_accept,
  input logic [1:0] mode,
  input logic       link_en,
  input logic       core_en,
  input logic       ring_det_en,
  input logic       link_ready,
  input logic       far_regs_valid
);

  assert_reset_gating_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!link_en && core_en && !ring_det_en && !link_ready && !far_regs_valid));

  assert_ready_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |-> (mode == 2'b00 && link_en && core_en));

  assert_deep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !host_accept) |=> (mode == 2'b11 || mode == 2'b10));

  assert_order_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && reg_we && reg_wdata == 2'b10 && !host_accept) |=> (mode == 2'b01));

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !host_accept) |=> (mode == 2'b10));

  assert_accept_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_accept |=> (mode == 2'b01));

  assert_live_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rst_req && clk_ok) |-> host_accept);

  assert_clock_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |-> !host_accept);

  assert_ring_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ring_det_en == (mode == 2'b00 || mode == 2'b10));

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_we         (reg_we),
  .reg_wdata      (reg_wdata),
  .host_rst_req   (host_rst_req),
  .clk_ok         (clk_ok),
  .host_accept    (host_accept),
  .mode           (mode),
  .link_en        (link_en),
  .core_en        (core_en),
  .ring_det_en    (ring_det_en),
  .link_ready     (link_ready),
  .far_regs_valid (far_regs_valid)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;

  localparam int ARM = 4;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_wdata = 2'b00;
  logic       host_rst_req = 1'b0;
  logic       clk_present = 1'b1;
  logic [1:0] mode;
  logic       link_en, core_en, ring_det_en, link_ready, far_regs_valid;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.ARM_CYCLES(ARM), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .host_rst_req(host_rst_req), .clk_present(clk_present), .mode(mode),
    .link_en(link_en), .core_en(core_en), .ring_det_en(ring_det_en),
    .link_ready(link_ready), .far_regs_valid(far_regs_valid)
  );

  // {mode, link, core, ring, ready, far} restated from the requirements
  function automatic logic [6:0] expect_for(logic [1:0] m);
    case (m)
      2'b00:   return {m, 5'b11111};
      2'b01:   return {m, 5'b01000};
      2'b10:   return {m, 5'b10101};
      default: return {m, 5'b00000};
    endcase
  endfunction

  task automatic check(string req, logic [1:0] exp_mode);
    logic [6:0] act, exp;
    act = {mode, link_en, core_en, ring_det_en, link_ready, far_regs_valid};
    exp = expect_for(exp_mode);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic write(logic [1:0] w);
    reg_we = 1'b1;
    reg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic host_reset();
    host_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    host_rst_req = 1'b0;
  endtask

  task automatic t_power_on();
    idle(SYNC + 1);
    check("R1 power-on mode", 2'b01);
    check("R2 reset gating", 2'b01);
  endtask

  task automatic t_normal_entry();
    write(2'b10);
    check("R7 out-of-order in reset", 2'b01);
    write(2'b00);
    check("R3 normal entry", 2'b00);
    check("R11 ring in normal", 2'b00);
    write(2'b10);
    check("R7 out-of-order in normal", 2'b00);
  endtask

  task automatic t_back_to_reset();
    write(2'b01);
    check("R4 normal back to reset", 2'b01);
    write(2'b00);
    check("R3 re-entry to normal", 2'b00);
  endtask

  task automatic t_sleep_entry();
    write(2'b11);
    check("R5 arming shows deep", 2'b11);
    idle(1);
    write(2'b10);
    check("R5 sleep entry", 2'b10);
    check("R11 ring in sleep", 2'b10);
  endtask

  task automatic t_sleep_ignores();
    write(2'b00);
    check("R8 sleep ignores 00", 2'b10);
    write(2'b01);
    check("R8 sleep ignores 01", 2'b10);
    write(2'b11);
    check("R8 sleep ignores 11", 2'b10);
  endtask

  task automatic t_host_reset_live();
    host_reset();
    check("R9 live reset from sleep", 2'b01);
    reg_we = 1'b1;
    reg_wdata = 2'b00;
    host_rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    host_rst_req = 1'b0;
    check("R9 reset beats write", 2'b01);
  endtask

  task automatic t_sleep_from_reset();
    write(2'b11);
    write(2'b10);
    check("R5 sleep straight from reset", 2'b10);
    host_reset();
    check("R9 reset after sleep", 2'b01);
  endtask

  task automatic t_window_edge();
    write(2'b00);
    write(2'b11);
    idle(ARM - 1);
    write(2'b10);
    check("R5 sleep on last window edge", 2'b10);
    host_reset();
  endtask

  task automatic t_deep_commit();
    write(2'b00);
    write(2'b11);
    idle(ARM);
    write(2'b10);
    check("R6 late sleep write ignored", 2'b11);
    write(2'b00);
    check("R8 deep ignores 00", 2'b11);
  endtask

  task automatic t_host_reset_pending();
    clk_present = 1'b0;
    idle(SYNC + 2);
    host_reset();
    idle(3);
    check("R10 held while clock absent", 2'b11);
    clk_present = 1'b1;
    idle(SYNC);
    check("R10 not yet accepted", 2'b11);
    idle(1);
    check("R10 accepted after sync", 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_power_on();
    t_normal_entry();
    t_back_to_reset();
    t_sleep_entry();
    t_sleep_ignores();
    t_host_reset_live();
    t_sleep_from_reset();
    t_window_edge();
    t_deep_commit();
    t_host_reset_pending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule